// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block is a bus master that works through a ring of transmit descriptors kept in a word-addressed memory shared with the host. Each descriptor spans four 32-bit words. The engine reads three of them. The status word at offset 0 carries the ownership flag. The control word at offset 1 holds the length and the segment, setup and wrap flags. The buffer byte address sits at offset 2. The word at offset 3 is reserved as the next pointer and is not read.

For every descriptor the host owns, the engine moves the buffer onto an outgoing byte stream with valid/ready flow control. It then writes a status word back that returns ownership to the host, with an error flag where one applies. Descriptors flagged as setup packets are sent out on a separate filter-load port and never reach the transmit stream.

The host controls the engine with a run enable and a one-cycle poll pulse. When the engine meets a descriptor it does not own, it suspends and stays quiet on the memory port until the next poll. Clearing the run enable parks the engine at a descriptor boundary. While stopped, the descriptor pointer follows the ring base input.

Top module: `txr_engine`

## Requirements
- R1: After reset `proc_state` is 0 and `tx_valid`, `flt_valid` and `mem_req` are all low until `run_en` is raised.
- R2: A descriptor at word address A is read as status at A, control at A+1 and buffer byte address at A+2. The engine processes it only when status bit 31 (ownership) is 1.
- R3: On reading a status word with bit 31 clear, the engine enters the suspended state (`proc_state` 6). It issues no memory access until `poll` is pulsed, and a poll makes it re-read the same descriptor.
- R4: Buffer bytes come out little-endian: byte k is bits [8*(k%4)+7 : 8*(k%4)] of word (buffer address/4 + k/4). There are exactly control[10:0] bytes. `tx_first` marks byte 0 when control bit 29 is set, and `tx_last` marks the final byte when control bit 30 is set.
- R5: While `tx_valid` is high and `tx_ready` and `tx_abort` are low, `tx_valid` and `tx_data` hold unchanged into the next cycle.
- R6: After each processed descriptor, one write goes to its status word. The written value has bit 31 clear, bit 15 (error summary) as the only other possible set bit, and bit 15 is clear on a clean completion.
- R7: A length field of zero sends no bytes and writes back status 0x00008000.
- R8: `tx_abort` high while `tx_valid` is high ends the buffer at once with no further bytes. The cycle after, the engine writes back status 0x00008000.
- R9: When control bit 27 (setup) is set, the bytes go out on `flt_data`/`flt_valid`, with `flt_last` on the final byte. None of them appear on the transmit stream.
- R10: After a descriptor whose control bit 25 (end of ring) is set, the next descriptor address is `ring_base`. Otherwise the next address is the current address plus 4 words.
- R11: With `run_en` low and the engine suspended or stopped, `proc_state` becomes 0 and `poll` is ignored. Raising `run_en` starts fetching at `ring_base`.
- R12: `proc_state` reads 1 while fetching a descriptor, 2 while moving buffer bytes, and 3 during the status write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Transmit process enable |
| poll | input | 1 | One-cycle poll demand |
| ring_base | input | AW | Word address of the first descriptor |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a first segment |
| tx_last | output | 1 | Final byte of a last segment |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_abort | input | 1 | Downstream error, ends the buffer |
| flt_valid | output | 1 | Filter-load byte valid (always accepted) |
| flt_data | output | 8 | Filter-load byte |
| flt_last | output | 1 | Final filter-load byte |
| proc_state | output | 3 | 0 stopped, 1 fetch, 2 transfer, 3 write-back, 6 suspended |

## Verification
The bench drives a length that crosses a word boundary while `tx_ready` toggles. A byte-lane or hold bug shows up there as a duplicated, dropped or reordered byte. A setup descriptor sits between ordinary ones, so a design that leaks it onto the wire puts unexpected bytes on the stream. A zero-length descriptor at the end of the ring checks both the error write-back and the wrap: a design that steps past the ring end reads address 28 instead of 16 when it suspends. An abort in the middle of a buffer, a poll while stopped, and a restart that must begin at the ring base catch designs that keep streaming after an error, react to polls while stopped, or resume from a stale pointer.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT = 31;
  localparam int LS_BIT  = 30;
  localparam int FS_BIT  = 29;
  localparam int SET_BIT = 27;
  localparam int EOR_BIT = 25;
  localparam int ES_BIT  = 15;

  localparam logic [2:0] PS_STOP = 3'd0;
  localparam logic [2:0] PS_FTCH = 3'd1;
  localparam logic [2:0] PS_XFER = 3'd2;
  localparam logic [2:0] PS_CLOS = 3'd3;
  localparam logic [2:0] PS_SUSP = 3'd6;

  typedef enum logic [3:0] {
    S_STOP, S_ST, S_STW, S_CT, S_CTW, S_BA, S_BAW,
    S_DR, S_DRW, S_OUT, S_WB, S_SUSP
  } txr_state_e;
endpackage

// File: rtl/txr_ptr.sv
module txr_ptr #(
  parameter int AW = 12,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          load_base,
  input  logic          advance,
  input  logic          eor,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic [AW-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst)            cur_q <= '0;
    else if (load_base) cur_q <= ring_base;
    else if (advance)   cur_q <= eor ? ring_base : cur_q + STEP;
  end

  assign cur = cur_q;

  // R10
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !eor && !load_base) |=> cur_q == $past(cur_q) + STEP);
  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && eor && !load_base) |=> cur_q == $past(ring_base));
endmodule

// File: rtl/txr_lane.sv
module txr_lane #(
  parameter int AW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic          word_load,
  input  logic [31:0]   word,
  input  logic          take,
  output logic [7:0]    byte_o,
  output logic          first,
  output logic          last,
  output logic          word_done,
  output logic [AW-1:0] wptr
);
  logic [LW-1:0] rem_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] wptr_q;
  logic [31:0]   word_q;
  logic          first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      idx_q   <= '0;
      wptr_q  <= '0;
      word_q  <= '0;
      first_q <= 1'b0;
    end else begin
      if (load) begin
        rem_q   <= len;
        idx_q   <= '0;
        wptr_q  <= base;
        first_q <= 1'b1;
      end else if (take) begin
        rem_q   <= rem_q - LW'(1);
        idx_q   <= idx_q + 2'd1;
        first_q <= 1'b0;
        if (idx_q == 2'd3) wptr_q <= wptr_q + AW'(1);
      end
      if (word_load) word_q <= word;
    end
  end

  assign byte_o    = word_q[{idx_q, 3'b000} +: 8];
  assign first     = first_q;
  assign last      = (rem_q == LW'(1));
  assign word_done = (idx_q == 2'd3);
  assign wptr      = wptr_q;

  // R4
  take_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> rem_q != '0);
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> rem_q == $past(rem_q) - LW'(1));
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          poll,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          tx_abort,
  output logic          flt_valid,
  output logic [7:0]    flt_data,
  output logic          flt_last,
  output logic [2:0]    proc_state
);
  txr_state_e    state;
  logic [31:0]   ctrl_q;
  logic          err_q;
  logic [AW-1:0] cur, wptr;
  logic [7:0]    lane_byte;
  logic          lane_first, lane_last, lane_wdone;
  logic          out_act, is_setup, take, abort_now;
  logic [LW-1:0] len_w;

  assign len_w     = ctrl_q[LW-1:0];
  assign out_act   = (state == S_OUT);
  assign is_setup  = ctrl_q[SET_BIT];
  assign abort_now = out_act && !is_setup && tx_abort;
  assign take      = out_act && (is_setup || (tx_ready && !tx_abort));

  txr_ptr #(.AW(AW), .STRIDE(4)) u_ptr (
    .clk(clk), .rst(rst), .ring_base(ring_base),
    .load_base(state == S_STOP), .advance(state == S_WB),
    .eor(ctrl_q[EOR_BIT]), .cur(cur)
  );

  txr_lane #(.AW(AW), .LW(LW)) u_lane (
    .clk(clk), .rst(rst),
    .load(state == S_BAW), .len(len_w), .base(mem_rdata[AW+1:2]),
    .word_load(state == S_DRW), .word(mem_rdata),
    .take(take), .byte_o(lane_byte), .first(lane_first),
    .last(lane_last), .word_done(lane_wdone), .wptr(wptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_STOP;
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        S_STOP: if (run_en) state <= S_ST;
        S_ST: begin
          err_q <= 1'b0;
          state <= S_STW;
        end
        S_STW:  state <= mem_rdata[OWN_BIT] ? S_CT : S_SUSP;
        S_CT:   state <= S_CTW;
        S_CTW: begin
          ctrl_q <= mem_rdata;
          state  <= S_BA;
        end
        S_BA:   state <= S_BAW;
        S_BAW: begin
          if (len_w == '0) begin
            err_q <= 1'b1;
            state <= S_WB;
          end else begin
            state <= S_DR;
          end
        end
        S_DR:   state <= S_DRW;
        S_DRW:  state <= S_OUT;
        S_OUT: begin
          if (abort_now) begin
            err_q <= 1'b1;
            state <= S_WB;
          end else if (take) begin
            if (lane_last)       state <= S_WB;
            else if (lane_wdone) state <= S_DR;
          end
        end
        S_WB:   state <= run_en ? S_ST : S_STOP;
        S_SUSP: begin
          if (!run_en)   state <= S_STOP;
          else if (poll) state <= S_ST;
        end
        default: state <= S_STOP;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = cur;
    unique case (state)
      S_ST: mem_req = 1'b1;
      S_CT: begin mem_req = 1'b1; mem_addr = cur + AW'(1); end
      S_BA: begin mem_req = 1'b1; mem_addr = cur + AW'(2); end
      S_DR: begin mem_req = 1'b1; mem_addr = wptr; end
      S_WB: mem_req = 1'b1;
      default: ;
    endcase
  end

  assign mem_we    = (state == S_WB);
  assign mem_wdata = {16'h0000, err_q, 15'h0000};

  assign tx_valid  = out_act && !is_setup;
  assign tx_data   = lane_byte;
  assign tx_first  = lane_first && ctrl_q[FS_BIT];
  assign tx_last   = lane_last && ctrl_q[LS_BIT];
  assign flt_valid = out_act && is_setup;
  assign flt_data  = lane_byte;
  assign flt_last  = lane_last;

  always_comb begin
    unique case (state)
      S_STOP:                   proc_state = PS_STOP;
      S_DR, S_DRW, S_OUT:       proc_state = PS_XFER;
      S_WB:                     proc_state = PS_CLOS;
      S_SUSP:                   proc_state = PS_SUSP;
      default:                  proc_state = PS_FTCH;
    endcase
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !tx_abort) |=> tx_valid && $stable(tx_data));
  // R3
  susp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_state == PS_SUSP && !poll) |=> !mem_req);
  // R8
  abort_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_abort) |=> mem_we && mem_wdata[ES_BIT] && !tx_valid);
  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_state == PS_STOP && !run_en) |=> proc_state == PS_STOP && !mem_req);
  // R9
  setup_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> !tx_valid);
endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;
  localparam int AW = 12;
  localparam int LW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, poll = 1'b0;
  logic [AW-1:0] ring_base = AW'(16);
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_first, tx_last, flt_valid, flt_last;
  logic [7:0] tx_data, flt_data;
  logic tx_ready = 1'b1, tx_abort = 1'b0;
  logic [2:0] proc_state;

  always #5 clk = ~clk;

  txr_engine #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .poll(poll), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_abort(tx_abort),
    .flt_valid(flt_valid), .flt_data(flt_data), .flt_last(flt_last),
    .proc_state(proc_state)
  );

  // Host memory model: registered read, host writes through one port
  logic [31:0] mem [0:(1<<AW)-1];
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_data = '0;
  always @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  int exp_tx[$];
  int exp_flt[$];
  int exp_wb[$];
  int ready_mode = 0, cyc = 0, acc_total = 0, abort_at = -1;
  int req_count = 0;
  int last_rd = -1;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: expected streams as queues, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      tx_abort = 1'b0;
      tx_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 != 0);
      if (tx_valid && abort_at >= 0 && acc_total == abort_at) begin
        tx_abort = 1'b1;
        abort_at = -1;
      end
      if (mem_req) req_count++;
      if (mem_req && !mem_we) last_rd = int'(mem_addr);
      if (tx_valid || flt_valid)
        chk(proc_state == 3'd2, "R12", "state in transfer", proc_state, 2);
      if (tx_valid && tx_ready && !tx_abort) begin
        acc_total++;
        if (exp_tx.size() == 0)
          chk(1'b0, "R9", "unexpected tx byte", tx_data, 0);
        else begin
          int e;
          e = exp_tx.pop_front();
          chk({tx_first, tx_last, tx_data} == e[9:0], "R4", "tx byte/flags",
              int'({tx_first, tx_last, tx_data}), e);
        end
      end
      if (flt_valid) begin
        if (exp_flt.size() == 0)
          chk(1'b0, "R9", "unexpected filter byte", flt_data, 0);
        else begin
          int e;
          e = exp_flt.pop_front();
          chk({flt_last, flt_data} == e[8:0], "R9", "filter byte",
              int'({flt_last, flt_data}), e);
        end
      end
      if (mem_req && mem_we) begin
        chk(proc_state == 3'd3, "R12", "state in write-back", proc_state, 3);
        if (exp_wb.size() == 0)
          chk(1'b0, "R6", "unexpected write-back", int'(mem_addr), 0);
        else begin
          int e;
          e = exp_wb.pop_front();
          chk({mem_addr, 1'b0, mem_wdata[31], mem_wdata[15]} == e[AW+2:0],
              "R6", "write-back addr/own/es",
              int'({mem_addr, 1'b0, mem_wdata[31], mem_wdata[15]}), e);
          chk(mem_wdata[30:16] == 0 && mem_wdata[14:0] == 0, "R6",
              "other status bits", mem_wdata, 0);
        end
      end
    end
  end

  task automatic hw(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Writes a descriptor and its buffer; queues what the engine should do
  task automatic desc(input int a, input int ctrl, input int bufb,
                      input int seed, input int keep, input bit es);
    int n;
    n = ctrl & 32'h7ff;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      int d;
      d = 0;
      for (int b = 0; b < 4; b++) d |= ((seed + w * 4 + b) & 8'hff) << (8 * b);
      hw(bufb / 4 + w, d);
    end
    for (int k = 0; k < keep; k++) begin
      int v;
      v = (seed + k) & 8'hff;
      if (ctrl[27]) exp_flt.push_back(((k == n - 1) << 8) | v);
      else exp_tx.push_back(((k == 0 && ctrl[29]) << 9) |
                            ((k == n - 1 && ctrl[30]) << 8) | v);
    end
    exp_wb.push_back((a << 3) | int'(es));
    hw(a + 1, ctrl);
    hw(a + 2, bufb);
    hw(a + 3, 0);
    hw(a, 32'h8000_0000);
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 3000 && proc_state != 3'd6; i++) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(exp_tx.size() == 0, req, "tx bytes left", exp_tx.size(), 0);
    chk(exp_flt.size() == 0, req, "filter bytes left", exp_flt.size(), 0);
    chk(exp_wb.size() == 0, req, "write-backs left", exp_wb.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 40; i++) hw(i, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(proc_state == 0, "R1", "proc_state", proc_state, 0);
    chk(!tx_valid && !flt_valid && !mem_req, "R1", "outputs idle",
        int'({tx_valid, flt_valid, mem_req}), 0);

    // Plain, setup, zero-length with end of ring
    desc(16, 32'h6000_0005, 32'h400, 8'h10, 5, 1'b0);             // R2 R4
    desc(20, 32'h0800_0008, 32'h500, 8'h40, 8, 1'b0);             // R9
    desc(24, 32'h0200_0000, 32'h600, 8'h00, 0, 1'b1);             // R7 R10
    run_en = 1'b1;
    @(negedge clk);
    wait_susp();
    chk(proc_state == 6, "R3", "suspended on foreign descriptor", proc_state, 6);
    chk(last_rd == 16, "R10", "wrapped to ring base", last_rd, 16);
    drained("R7");

    // Quiet while suspended
    req_count = 0;
    repeat (20) @(negedge clk);
    chk(req_count == 0, "R3", "no access while suspended", req_count, 0);

    // Multi-word buffer under backpressure
    ready_mode = 1;
    desc(16, 32'h6000_0009, 32'h700, 8'h80, 9, 1'b0);             // R5
    pulse_poll();
    wait_susp();
    chk(last_rd == 20, "R3", "stopped at next descriptor", last_rd, 20);
    drained("R5");
    ready_mode = 0;

    // Abort mid-buffer
    desc(20, 32'h6000_0006, 32'h800, 8'hC0, 2, 1'b1);             // R8
    abort_at = acc_total + 2;
    pulse_poll();
    wait_susp();
    chk(last_rd == 24, "R8", "advanced after abort", last_rd, 24);
    drained("R8");

    // Stop, poll ignored, restart at ring base
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(proc_state == 0, "R11", "stopped", proc_state, 0);
    hw(24 + 1, 32'h6000_0002);
    hw(24, 32'h8000_0000);
    req_count = 0;
    pulse_poll();
    repeat (20) @(negedge clk);
    chk(req_count == 0 && proc_state == 0, "R11", "poll ignored when stopped",
        req_count, 0);
    run_en = 1'b1;
    @(negedge clk);
    wait_susp();
    chk(last_rd == 16, "R11", "restart reads ring base", last_rd, 16);
    chk(proc_state == 6, "R11", "suspended after restart", proc_state, 6);
    drained("R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule